// File: doc/BRIEF.md
# Dual-Port Global Control/Status Register Bank

This block holds eight byte-wide control and status registers. Two masters can reach them. One is the local processor bus. The other is a 16-bit short address space on the system backplane. The registers sit on 2-byte strides, so register `i` lives at byte offset `2*i`.

A backplane cycle claims the bank only when its upper address byte matches an 8-bit group switch and its next nibble matches a 4-bit board switch. Both switch values can also be read back as read-only registers.

The bank serves several purposes. Remote processors use it to signal, control and query the local board. Four active-low monitor bits act as a doorbell: a monitor hit clears one bit and raises a level interrupt. The interrupt stays up until the backplane writes the cleared bits back to 1.

Illegal widths are handled differently on each port. A 32-bit backplane access is ignored with no acknowledge, so an external timeout ends it. A 32-bit local read returns the addressed register mirrored into both 16-bit halves.

Both ports use a single-cycle request/acknowledge handshake. The acknowledge and read data are combinational in the request cycle, and a write commits at the next clock edge. When both ports contend, a fixed arbiter serves the backplane first and holds the local acknowledge low.

Top module: `glb_csr_bank`

## Requirements
- R1: After reset, the registers read as follows:
  - index 0 reads 0x0F (four monitors armed);
  - index 1 reads the group switch;
  - index 2 reads {4'h0, board switch};
  - every other index reads 0x00;
  - `irq` is low.
- R2: Register index `i` is reached at byte offset `2*i` (address bits 3:1). Address bit 0 is ignored. Indices 5, 6 and 7 are plain read/write from both ports.
- R3: A backplane request with `bp_wide` high never gets `bp_ack` and changes no register.
- R4: A local read returns the register in bits 7:0, with bits 15:8 zero. With `loc_wide` high, bits 31:16 copy bits 15:0; otherwise bits 31:16 are zero.
- R5: `bp_ack` is given only when `bp_addr[15:8]` equals `grp_sw` and `bp_addr[7:4]` equals `brd_sw`. Any other backplane address leaves the bank untouched.
- R6: Indices 1 and 2 are read-only. Writes to them from either port are acknowledged and ignored.
- R7: Index 3 is a bit set/clear register with seven stored bits:
  - a write with data bit 7 = 1 sets each stored bit 6:0 whose data bit is 1;
  - a write with data bit 7 = 0 clears each stored bit 6:0 whose data bit is 1;
  - stored bits whose data bit is 0 keep their value;
  - bit 7 always reads 0.
- R8: Index 4 is written only from the local port. A backplane write to it is acknowledged but leaves the value unchanged.
- R9: On a clock with `lm_strobe` high and `lm_addr[15:8]` equal to `grp_sw`, monitor bit `lm_addr[2:1]` of index 0 (bits 3:0, active low) clears to 0. `irq` is high whenever any monitor bit is 0. A strobe with another group byte has no effect.
- R10: Index 0 bits 7:4 are read/write from both ports. Bits 3:0 are re-armed only by a backplane write: each data bit that is 1 sets its monitor, and data bits that are 0 change nothing. Local writes never change bits 3:0. After a re-arm, the same monitor can be hit and detected again.
- R11: When a valid backplane request and a local request arrive in the same cycle, only the backplane is acknowledged. The local request is acknowledged once the backplane request is gone.
- R12: An acknowledge appears in the same cycle as its request, with read data valid in that cycle. A write takes effect at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_sw | input | 8 | Group address switch |
| brd_sw | input | 4 | Board address switch |
| loc_req | input | 1 | Local access request |
| loc_we | input | 1 | Local write enable |
| loc_wide | input | 1 | Local 4-byte access |
| loc_addr | input | 4 | Local byte offset |
| loc_wdata | input | 8 | Local write data |
| loc_ack | output | 1 | Local acknowledge (ready) |
| loc_rdata | output | 32 | Local read data |
| bp_req | input | 1 | Backplane access request |
| bp_we | input | 1 | Backplane write enable |
| bp_wide | input | 1 | Backplane 32-bit access |
| bp_addr | input | 16 | Backplane short address |
| bp_wdata | input | 8 | Backplane write data |
| bp_ack | output | 1 | Backplane acknowledge |
| bp_rdata | output | 8 | Backplane read data |
| lm_strobe | input | 1 | Monitor hit strobe |
| lm_addr | input | 16 | Address seen by the monitors |
| irq | output | 1 | Level interrupt request, high while any monitor is hit |

## Verification
The assertions assume the following about each master:
- it holds its request only until it sees the acknowledge;
- it keeps its fields stable while the request is up;
- the switches change only while both ports are idle.

They also assume that no monitor strobe lands in the same cycle as a backplane re-arm of index 0. The interrupt-hold property relies on that separation.

The bench keeps within these assumptions in three ways:
- every access lasts exactly one clock, driven at the falling edge;
- the switches are moved only between accesses;
- monitor strobes are issued on their own clocks.

// File: rtl/glb_csr_pkg.sv
package glb_csr_pkg;

   localparam int unsigned REG_COUNT = 8;
   localparam int unsigned IDX_W     = 3;

   typedef enum logic [IDX_W-1:0] {
      IDX_MON = 3'd0,
      IDX_GRP = 3'd1,
      IDX_BRD = 3'd2,
      IDX_CTL = 3'd3,
      IDX_LOC = 3'd4,
      IDX_GP0 = 3'd5,
      IDX_GP1 = 3'd6,
      IDX_GP2 = 3'd7
   } reg_idx_e;

   typedef struct packed {
      logic             en;
      logic             from_bp;
      logic [IDX_W-1:0] idx;
      logic [7:0]       data;
   } wr_cmd_t;

endpackage

// File: rtl/glb_csr_decode.sv
module glb_csr_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned GRP_W  = 8,
   parameter int unsigned BRD_W  = 4
) (
   input  logic                           req,
   input  logic                           wide,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [GRP_W-1:0]               grp,
   input  logic [BRD_W-1:0]               brd,
   output logic                           sel,
   output logic [glb_csr_pkg::IDX_W-1:0]  idx
);
   localparam int unsigned OFF_W   = ADDR_W - GRP_W - BRD_W;
   localparam int unsigned BRD_LSB = OFF_W;
   localparam int unsigned GRP_LSB = OFF_W + BRD_W;

   if (OFF_W != glb_csr_pkg::IDX_W + 1) begin : g_bad_split
      $error("decode: offset field must hold eight registers on 2-byte strides");
   end

   logic grp_hit, brd_hit;

   assign grp_hit = (addr[ADDR_W-1:GRP_LSB] == grp);
   assign brd_hit = (addr[GRP_LSB-1:BRD_LSB] == brd);
   assign sel     = req && !wide && grp_hit && brd_hit;
   assign idx     = addr[OFF_W-1:1];

endmodule

// File: rtl/glb_csr_arb.sv
module glb_csr_arb #(
   parameter bit BP_FIRST = 1'b1
) (
   input  logic bp_sel,
   input  logic loc_req,
   output logic bp_gnt,
   output logic loc_gnt
);
   if (BP_FIRST) begin : g_bp_first
      assign bp_gnt  = bp_sel;
      assign loc_gnt = loc_req && !bp_sel;
   end else begin : g_loc_first
      assign loc_gnt = loc_req;
      assign bp_gnt  = bp_sel && !loc_req;
   end
endmodule

// File: rtl/glb_csr_regs.sv
module glb_csr_regs
   import glb_csr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LM_N   = 4,
   parameter int unsigned GRP_W  = 8,
   parameter int unsigned BRD_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_cmd_t           wr,
   input  logic [LM_N-1:0]   lm_hit_vec,
   input  logic [GRP_W-1:0]  grp,
   input  logic [BRD_W-1:0]  brd,
   input  logic [IDX_W-1:0]  rd_idx_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic              irq
);
   localparam int unsigned NUM_GP  = 3;
   localparam int unsigned GP_BASE = 5;
   localparam int unsigned HI_W    = DATA_W - LM_N;
   localparam int unsigned CTL_W   = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("regs: register width must be one byte");
   end
   if (LM_N > DATA_W / 2) begin : g_bad_lm
      $error("regs: monitor bits must fit the low nibble");
   end
   if (GRP_W > DATA_W || BRD_W > DATA_W) begin : g_bad_sw
      $error("regs: switch fields must fit a register");
   end

   logic [LM_N-1:0]   lm_q, lm_nxt;
   logic [HI_W-1:0]   mon_hi_q;
   logic [CTL_W-1:0]  ctl_q;
   logic [DATA_W-1:0] loc_q;
   logic [DATA_W-1:0] gp_q [NUM_GP];
   logic [DATA_W-1:0] view [REG_COUNT];

   // monitors: backplane write re-arms, hit clears (hit wins)
   always_comb begin
      lm_nxt = lm_q;
      if (wr.en && wr.from_bp && reg_idx_e'(wr.idx) == IDX_MON)
         lm_nxt = lm_nxt | wr.data[LM_N-1:0];
      lm_nxt = lm_nxt & ~lm_hit_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lm_q <= '1;
      else        lm_q <= lm_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_hi_q <= '0;
         ctl_q    <= '0;
         loc_q    <= '0;
      end else if (wr.en) begin
         case (reg_idx_e'(wr.idx))
            IDX_MON: mon_hi_q <= wr.data[DATA_W-1:LM_N];
            IDX_CTL: begin
               if (wr.data[DATA_W-1]) ctl_q <= ctl_q | wr.data[CTL_W-1:0];
               else                   ctl_q <= ctl_q & ~wr.data[CTL_W-1:0];
            end
            IDX_LOC: if (!wr.from_bp) loc_q <= wr.data;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
      always_ff @(posedge clk) begin
         if (!rst_n)
            gp_q[g] <= '0;
         else if (wr.en && wr.idx == IDX_W'(GP_BASE + g))
            gp_q[g] <= wr.data;
      end
   end

   always_comb begin
      view[IDX_MON] = {mon_hi_q, lm_q};
      view[IDX_GRP] = DATA_W'(grp);
      view[IDX_BRD] = DATA_W'(brd);
      view[IDX_CTL] = {1'b0, ctl_q};
      view[IDX_LOC] = loc_q;
      for (int g = 0; g < NUM_GP; g++)
         view[GP_BASE + g] = gp_q[g];
   end

   assign rd_a = view[rd_idx_a];
   assign rd_b = view[rd_idx_b];
   assign irq  = ~&lm_q;

endmodule

// File: rtl/glb_csr_bank.sv
module glb_csr_bank
   import glb_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned GRP_W    = 8,
   parameter int unsigned BRD_W    = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned LM_N     = 4,
   parameter int unsigned LOC_W    = 32,
   parameter bit          BP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GRP_W-1:0]  grp_sw,
   input  logic [BRD_W-1:0]  brd_sw,
   input  logic              loc_req,
   input  logic              loc_we,
   input  logic              loc_wide,
   input  logic [3:0]        loc_addr,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic              loc_ack,
   output logic [LOC_W-1:0]  loc_rdata,
   input  logic              bp_req,
   input  logic              bp_we,
   input  logic              bp_wide,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic [DATA_W-1:0] bp_wdata,
   output logic              bp_ack,
   output logic [DATA_W-1:0] bp_rdata,
   input  logic              lm_strobe,
   input  logic [ADDR_W-1:0] lm_addr,
   output logic              irq
);
   localparam int unsigned HALF_W   = LOC_W / 2;
   localparam int unsigned LM_IDX_W = (LM_N > 1) ? $clog2(LM_N) : 1;
   localparam int unsigned GRP_LSB  = ADDR_W - GRP_W;

   if (LOC_W != 4 * DATA_W) begin : g_bad_loc
      $error("bank: local data path must be four bytes");
   end

   logic             bp_sel, bp_gnt, loc_gnt;
   logic [IDX_W-1:0] bp_idx, loc_idx;
   logic [DATA_W-1:0] loc_byte;
   logic [HALF_W-1:0] loc_half;
   logic [LM_N-1:0]  lm_hit_vec;
   wr_cmd_t          wr;

   glb_csr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .BRD_W(BRD_W)) u_dec (
      .req  (bp_req),
      .wide (bp_wide),
      .addr (bp_addr),
      .grp  (grp_sw),
      .brd  (brd_sw),
      .sel  (bp_sel),
      .idx  (bp_idx)
   );

   glb_csr_arb #(.BP_FIRST(BP_FIRST)) u_arb (
      .bp_sel  (bp_sel),
      .loc_req (loc_req),
      .bp_gnt  (bp_gnt),
      .loc_gnt (loc_gnt)
   );

   assign loc_idx = loc_addr[3:1];
   assign bp_ack  = bp_gnt;
   assign loc_ack = loc_gnt;

   always_comb begin
      wr = '0;
      if (bp_gnt && bp_we) begin
         wr.en = 1'b1; wr.from_bp = 1'b1; wr.idx = bp_idx; wr.data = bp_wdata;
      end else if (loc_gnt && loc_we) begin
         wr.en = 1'b1; wr.from_bp = 1'b0; wr.idx = loc_idx; wr.data = loc_wdata;
      end
   end

   always_comb begin
      lm_hit_vec = '0;
      if (lm_strobe && lm_addr[ADDR_W-1:GRP_LSB] == grp_sw)
         lm_hit_vec[lm_addr[LM_IDX_W:1]] = 1'b1;
   end

   glb_csr_regs #(.DATA_W(DATA_W), .LM_N(LM_N), .GRP_W(GRP_W), .BRD_W(BRD_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr),
      .lm_hit_vec (lm_hit_vec),
      .grp        (grp_sw),
      .brd        (brd_sw),
      .rd_idx_a   (loc_idx),
      .rd_idx_b   (bp_idx),
      .rd_a       (loc_byte),
      .rd_b       (bp_rdata),
      .irq        (irq)
   );

   assign loc_half  = HALF_W'(loc_byte);
   assign loc_rdata = {(loc_wide ? loc_half : '0), loc_half};

   logic unused_addr_bits;
   assign unused_addr_bits = ^{loc_addr[0], lm_addr[GRP_LSB-1:LM_IDX_W+1], lm_addr[0]};

endmodule

// File: rtl/glb_csr_bank_chk.sv
module glb_csr_bank_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned GRP_W  = 8,
   parameter int unsigned BRD_W  = 4,
   parameter int unsigned LOC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GRP_W-1:0]  grp_sw,
   input logic [BRD_W-1:0]  brd_sw,
   input logic              loc_req,
   input logic              loc_wide,
   input logic              loc_ack,
   input logic [LOC_W-1:0]  loc_rdata,
   input logic              bp_req,
   input logic              bp_we,
   input logic              bp_wide,
   input logic [ADDR_W-1:0] bp_addr,
   input logic              bp_ack,
   input logic              irq
);
   localparam int unsigned HALF_W  = LOC_W / 2;
   localparam int unsigned GRP_LSB = ADDR_W - GRP_W;
   localparam int unsigned BRD_LSB = GRP_LSB - BRD_W;

   logic bp_rearm;
   assign bp_rearm = bp_ack && bp_we && (bp_addr[BRD_LSB-1:1] == '0);

   AST_BP_WIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_req && bp_wide) |-> !bp_ack); // R3

   AST_BP_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      bp_ack |-> (bp_addr[ADDR_W-1:GRP_LSB] == grp_sw && bp_addr[GRP_LSB-1:BRD_LSB] == brd_sw)); // R5

   AST_LOC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_ack && loc_wide) |-> (loc_rdata[LOC_W-1:HALF_W] == loc_rdata[HALF_W-1:0])); // R4

   AST_BP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_ack && loc_req) |-> !loc_ack); // R11

   AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_ack || bp_ack) |-> ((loc_ack ? loc_req : 1'b1) && (bp_ack ? bp_req : 1'b1))); // R12

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bp_rearm) |=> irq); // R9

endmodule

bind glb_csr_bank glb_csr_bank_chk #(
   .ADDR_W(ADDR_W), .GRP_W(GRP_W), .BRD_W(BRD_W), .LOC_W(LOC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grp_sw    (grp_sw),
   .brd_sw    (brd_sw),
   .loc_req   (loc_req),
   .loc_wide  (loc_wide),
   .loc_ack   (loc_ack),
   .loc_rdata (loc_rdata),
   .bp_req    (bp_req),
   .bp_we     (bp_we),
   .bp_wide   (bp_wide),
   .bp_addr   (bp_addr),
   .bp_ack    (bp_ack),
   .irq       (irq)
);

// File: tb/glb_csr_bank_tb_top.sv
module glb_csr_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  grp_sw = 8'h5A;
   logic [3:0]  brd_sw = 4'h3;
   logic        loc_req = 0, loc_we = 0, loc_wide = 0;
   logic [3:0]  loc_addr = '0;
   logic [7:0]  loc_wdata = '0;
   logic        loc_ack;
   logic [31:0] loc_rdata;
   logic        bp_req = 0, bp_we = 0, bp_wide = 0;
   logic [15:0] bp_addr = '0;
   logic [7:0]  bp_wdata = '0;
   logic        bp_ack;
   logic [7:0]  bp_rdata;
   logic        lm_strobe = 0;
   logic [15:0] lm_addr = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   logic [3:0] m_hi = '0, m_lm = 4'hF;
   logic [6:0] m_ctl = '0;
   logic [7:0] m_loc = '0;
   logic [7:0] m_gp [3] = '{8'h0, 8'h0, 8'h0};

   always #2 clk = ~clk;

   glb_csr_bank dut_i (.*);

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog expired act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_reg(input int idx);
      case (idx)
         0: return {m_hi, m_lm};
         1: return grp_sw;
         2: return {4'h0, brd_sw};
         3: return {1'b0, m_ctl};
         4: return m_loc;
         default: return m_gp[idx-5];
      endcase
   endfunction

   task automatic model_wr(input bit from_bp, input int idx, input logic [7:0] d);
      case (idx)
         0: begin m_hi = d[7:4]; if (from_bp) m_lm = m_lm | d[3:0]; end
         3: m_ctl = d[7] ? (m_ctl | d[6:0]) : (m_ctl & ~d[6:0]);
         4: if (!from_bp) m_loc = d;
         5, 6, 7: m_gp[idx-5] = d;
         default: ;
      endcase
   endtask

   function automatic logic [15:0] bpa(input int idx);
      return {grp_sw, brd_sw, 3'(idx), 1'b0};
   endfunction

   task automatic bp_op(input logic [15:0] a, input bit we, input bit wide,
                        input logic [7:0] d, output logic [7:0] rd, output logic ack);
      @(negedge clk);
      bp_addr = a; bp_we = we; bp_wide = wide; bp_wdata = d; bp_req = 1;
      #1; rd = bp_rdata; ack = bp_ack;
      @(posedge clk); #1;
      bp_req = 0; bp_we = 0; bp_wide = 0;
   endtask

   task automatic loc_op(input logic [3:0] a, input bit we, input bit wide,
                         input logic [7:0] d, output logic [31:0] rd, output logic ack);
      @(negedge clk);
      loc_addr = a; loc_we = we; loc_wide = wide; loc_wdata = d; loc_req = 1;
      #1; rd = loc_rdata; ack = loc_ack;
      @(posedge clk); #1;
      loc_req = 0; loc_we = 0; loc_wide = 0;
   endtask

   task automatic lm_hit(input logic [7:0] grp, input int n);
      @(negedge clk);
      lm_addr = {grp, 5'b10110, 2'(n), 1'b1}; lm_strobe = 1;
      @(posedge clk); #1;
      lm_strobe = 0;
   endtask

   initial begin
      logic [7:0]  brd8;
      logic [31:0] lrd;
      logic        ack;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset values
      chk("R1 irq at reset", 32'(irq), 32'h0);
      for (int i = 0; i < 8; i++) begin
         loc_op(4'(2*i), 0, 0, 8'h00, lrd, ack);
         chk("R1 reset read", lrd, {24'h0, exp_reg(i)});
      end

      // R2/R6/R7/R8/R10 sweep: local write -> backplane read, backplane write -> local read
      for (int i = 0; i < 8; i++) begin
         for (int p = 0; p < 6; p++) begin
            logic [7:0] d = 8'(p * 8'h35 + i * 8'h11 + 8'h81);
            loc_op(4'(2*i + (p & 1)), 1, 0, d, lrd, ack);
            chk("R12 local write ack", 32'(ack), 32'h1);
            model_wr(0, i, d);
            bp_op(bpa(i) | 16'(p & 1), 0, 0, 8'h00, brd8, ack);
            chk("R2 R6 R7 R8 R10 bp read after local write", {23'h0, ack, brd8}, {23'h0, 1'b1, exp_reg(i)});
            d = ~d;
            bp_op(bpa(i), 1, 0, d, brd8, ack);
            model_wr(1, i, d);
            loc_op(4'(2*i + 1), 0, 0, 8'h00, lrd, ack);
            chk("R2 R6 R7 R8 R10 local read after bp write", lrd, {24'h0, exp_reg(i)});
         end
      end

      // R4 wide local reads mirror both halves
      for (int i = 0; i < 8; i++) begin
         loc_op(4'(2*i), 0, 1, 8'h00, lrd, ack);
         chk("R4 wide mirror", lrd, {8'h0, exp_reg(i), 8'h0, exp_reg(i)});
      end

      // R3 backplane 32-bit access ignored
      bp_op(bpa(5), 1, 1, 8'hC3, brd8, ack);
      chk("R3 wide no ack", 32'(ack), 32'h0);
      loc_op(4'd10, 0, 0, 8'h00, lrd, ack);
      chk("R3 wide no write", lrd, {24'h0, exp_reg(5)});

      // R5 decode sweep over board switch
      for (int b = 0; b < 16; b++) begin
         @(negedge clk); brd_sw = 4'(b);
         bp_op(bpa(2), 0, 0, 8'h00, brd8, ack);
         chk("R5 board match", {23'h0, ack, brd8}, {23'h0, 1'b1, 4'h0, 4'(b)});
         bp_op({grp_sw, 4'(b) ^ 4'h1, 3'd6, 1'b0}, 1, 0, 8'h99, brd8, ack);
         chk("R5 board mismatch no ack", 32'(ack), 32'h0);
      end
      bp_op({grp_sw ^ 8'h80, brd_sw, 3'd6, 1'b0}, 1, 0, 8'h77, brd8, ack);
      chk("R5 group mismatch no ack", 32'(ack), 32'h0);
      loc_op(4'd12, 0, 0, 8'h00, lrd, ack);
      chk("R5 mismatch left reg intact", lrd, {24'h0, exp_reg(6)});

      // R9/R10 location monitors
      for (int n = 0; n < 4; n++) begin
         lm_hit(grp_sw ^ 8'h01, n);
         chk("R9 foreign group no irq", 32'(irq), 32'h0);
         lm_hit(grp_sw, n);
         m_lm[n] = 1'b0;
         chk("R9 hit raises irq", 32'(irq), 32'h1);
         loc_op(4'd0, 0, 0, 8'h00, lrd, ack);
         chk("R9 monitor bit cleared", lrd, {24'h0, exp_reg(0)});
         loc_op(4'd0, 1, 0, 8'h0F, lrd, ack);
         model_wr(0, 0, 8'h0F);
         chk("R10 local write no re-arm", 32'(irq), 32'h1);
         bp_op(bpa(0), 1, 0, 8'h00, brd8, ack);
         model_wr(1, 0, 8'h00);
         chk("R10 zero data no re-arm", 32'(irq), 32'h1);
         bp_op(bpa(0), 1, 0, 8'(1 << n), brd8, ack);
         model_wr(1, 0, 8'(1 << n));
         chk("R10 bp re-arm clears irq", 32'(irq), 32'h0);
         lm_hit(grp_sw, n);
         m_lm[n] = 1'b0;
         chk("R10 repeat hit detected", 32'(irq), 32'h1);
         bp_op(bpa(0), 1, 0, 8'h0F, brd8, ack);
         model_wr(1, 0, 8'h0F);
         chk("R10 full re-arm", {31'h0, irq}, 32'h0);
      end

      // R11 arbitration
      @(negedge clk);
      bp_addr = bpa(5); bp_we = 1; bp_wdata = 8'hA5; bp_req = 1;
      loc_addr = 4'd10; loc_we = 1; loc_wdata = 8'h3C; loc_req = 1;
      #1;
      chk("R11 bp granted", {30'h0, bp_ack, loc_ack}, 32'h2);
      @(posedge clk); #1;
      bp_req = 0; bp_we = 0;
      #1;
      chk("R11 local after bp", 32'(loc_ack), 32'h1);
      @(posedge clk); #1;
      loc_req = 0; loc_we = 0;
      model_wr(1, 5, 8'hA5); model_wr(0, 5, 8'h3C);
      bp_op(bpa(5), 0, 0, 8'h00, brd8, ack);
      chk("R11 final order", 32'(brd8), 32'(exp_reg(5)));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule